// File: doc/BRIEF.md
# Host Keyboard Controller Register Block

This block sits between a host processor and a keyboard. The host sees a status/command port and a data port. The keyboard side delivers key events as a 7-bit scan code and a release flag. Accepted key events are stored in a circular scan-code queue, and each one raises a keyboard interrupt pulse. The host reads the queued bytes through the data port.

Writes to the command port run controller commands. Some commands place one byte in a response register, and a data-port read returns that byte before any queued scan code. Other commands arm a pending-argument state, so that the next data-port write becomes their operand. That operand can replace the configuration byte, set the A20 gate and request a system reset, or insert a byte into the scan-code queue. Status bit 3 tells the host whether its next data write will be taken as such an argument.

Top module: `kbc_top`

## Requirements
- R1: The status byte has bit 0 set when a response is pending or the queue holds a byte, bit 2 always set, bit 3 set while an argument is awaited, and all other bits zero. After reset it reads 0x04.
- R2: Command 0x20 loads the configuration byte into the response register, 0xAA loads 0x55 and 0xA9 loads 0x00. The response is visible on the cycle after the command write.
- R3: Commands 0x60 and 0xD1 through 0xD4 set the argument-pending state. The next data-port write is consumed as their operand and clears that state.
- R4: The operand of 0x60 replaces the configuration byte, which resets to the parameter CFG_INIT.
- R5: The operand of 0xD1 copies its bit 1 to the A20 gate and issues a one-cycle reset request when its bit 0 is 0. The A20 gate is 1 after reset.
- R6: Every even command from 0xF0 to 0xFE issues a one-cycle system reset request on the following cycle. Odd commands in that range do not.
- R7: A data read returns the pending response and clears it. With no response pending, it returns and removes the oldest queued byte, or returns 0x00 when the queue is empty.
- R8: A key event is queued as {release, code}, so a release has bit 7 set. Bytes leave the queue in arrival order, and each accepted key event gives a one-cycle interrupt pulse on the next cycle.
- R9: With DEPTH bytes queued, a key event is refused: no interrupt, and the queue contents are unchanged. The pointers wrap around correctly.
- R10: The operand of 0xD2 is pushed into the queue without raising an interrupt.
- R11: Unrecognised commands change neither the pending response nor the argument-pending state. A data write while no argument is awaited has no effect.
- R12: If a key event and a 0xD2 operand arrive in the same cycle, the key event is queued and the operand is dropped. If a command write and a data write arrive in the same cycle, only the command is executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Host write strobe for the command port |
| data_wr | input | 1 | Host write strobe for the data port |
| data_rd | input | 1 | Host read strobe for the data port (consumes rd_data) |
| wr_data | input | 8 | Host write byte |
| status_o | output | 8 | Status byte |
| rd_data | output | 8 | Byte a data read would return |
| key_valid | input | 1 | Key event strobe |
| key_code | input | 7 | Scan code of the key event |
| key_release | input | 1 | 1 for a key release, 0 for a press |
| kbd_irq | output | 1 | Keyboard interrupt pulse |
| sys_reset_req | output | 1 | System reset request pulse |
| a20_gate | output | 1 | A20 gate level |

## Verification
The bench builds the block with DEPTH set to 4 and CFG_INIT left at 0x41. With a four-entry queue, a full queue, the refused fifth key event and the wrap of both pointers all occur within a few key events, so the full-queue and wrap cases are exercised directly. The known CFG_INIT value lets the bench check the 0x20 read before and after the configuration byte is rewritten.

// File: rtl/kbc_pkg.sv
// Package kbc_pkg: command opcodes, argument kinds and the decoded-command
// record shared by the keyboard controller modules.
package kbc_pkg;

    localparam logic [7:0] OP_READ_CFG   = 8'h20;
    localparam logic [7:0] OP_WRITE_CFG  = 8'h60;
    localparam logic [7:0] OP_AUX_TEST   = 8'hA9;
    localparam logic [7:0] OP_SELF_TEST  = 8'hAA;
    localparam logic [7:0] OP_WRITE_OUTP = 8'hD1;
    localparam logic [7:0] OP_KBUF_WRITE = 8'hD2;
    localparam logic [7:0] OP_AUXO_WRITE = 8'hD3;
    localparam logic [7:0] OP_AUXI_WRITE = 8'hD4;

    localparam logic [7:0] SELF_TEST_OK  = 8'h55;
    localparam logic [7:0] AUX_TEST_OK   = 8'h00;

    typedef enum logic [2:0] {
        ARG_CFG,
        ARG_OUTPORT,
        ARG_KEYBUF,
        ARG_AUXOUT,
        ARG_AUXIN
    } arg_kind_e;

    typedef struct packed {
        logic       gives_resp;
        logic       resp_from_cfg;
        logic [7:0] resp_const;
        logic       takes_arg;
        arg_kind_e  arg_kind;
        logic       sys_reset;
    } cmd_dec_t;

endpackage

// File: rtl/kbc_cmd_decode.sv
// Module kbc_cmd_decode: combinational decode of a command-port byte.
// Assumes the caller qualifies the result with the command write strobe.
// Unknown opcodes decode to an all-inactive record.
module kbc_cmd_decode
    import kbc_pkg::*;
(
    input  logic [7:0] cmd_i,
    output cmd_dec_t   dec_o
);

    // Map the opcode onto response, argument and reset actions
    always_comb begin
        dec_o = '{gives_resp: 1'b0, resp_from_cfg: 1'b0, resp_const: 8'h00,
                  takes_arg: 1'b0, arg_kind: ARG_CFG, sys_reset: 1'b0};
        case (cmd_i)
            OP_READ_CFG: begin
                dec_o.gives_resp    = 1'b1;
                dec_o.resp_from_cfg = 1'b1;
            end
            OP_SELF_TEST: begin
                dec_o.gives_resp = 1'b1;
                dec_o.resp_const = SELF_TEST_OK;
            end
            OP_AUX_TEST: begin
                dec_o.gives_resp = 1'b1;
                dec_o.resp_const = AUX_TEST_OK;
            end
            OP_WRITE_CFG: begin
                dec_o.takes_arg = 1'b1;
                dec_o.arg_kind  = ARG_CFG;
            end
            OP_WRITE_OUTP: begin
                dec_o.takes_arg = 1'b1;
                dec_o.arg_kind  = ARG_OUTPORT;
            end
            OP_KBUF_WRITE: begin
                dec_o.takes_arg = 1'b1;
                dec_o.arg_kind  = ARG_KEYBUF;
            end
            OP_AUXO_WRITE: begin
                dec_o.takes_arg = 1'b1;
                dec_o.arg_kind  = ARG_AUXOUT;
            end
            OP_AUXI_WRITE: begin
                dec_o.takes_arg = 1'b1;
                dec_o.arg_kind  = ARG_AUXIN;
            end
            default: begin
                dec_o.sys_reset = (cmd_i[7:4] == 4'hF) && !cmd_i[0];
            end
        endcase
    end

endmodule

// File: rtl/kbc_scan_fifo.sv
// Module kbc_scan_fifo: circular byte queue with read and write pointers and
// an explicit empty flag, so all DEPTH slots are usable. A push is refused
// when the queue is full, even if a pop happens in the same cycle. A pop
// from an empty queue does nothing. DEPTH need not be a power of two.
module kbc_scan_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] push_data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] head_o,
    output logic             empty_o,
    output logic             full_o,
    output logic             accept_o
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr_q, rd_ptr_q;
    logic             empty_q;
    logic             pop_ok;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + PW'(1);
    endfunction

    // Derive occupancy flags and the accepted operations
    always_comb begin
        full_o   = !empty_q && (wr_ptr_q == rd_ptr_q);
        empty_o  = empty_q;
        accept_o = push_i && !full_o;
        pop_ok   = pop_i && !empty_q;
        head_o   = mem[rd_ptr_q];
    end

    // Store an accepted byte at the write pointer
    always_ff @(posedge clk) begin
        if (accept_o) mem[wr_ptr_q] <= push_data_i;
    end

    // Advance the pointers and track emptiness
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            empty_q  <= 1'b1;
        end else begin
            if (accept_o) wr_ptr_q <= bump(wr_ptr_q);
            if (pop_ok)   rd_ptr_q <= bump(rd_ptr_q);
            if (accept_o)
                empty_q <= 1'b0;
            else if (pop_ok && (bump(rd_ptr_q) == wr_ptr_q))
                empty_q <= 1'b1;
        end
    end

endmodule

// File: rtl/kbc_top.sv
// Module kbc_top: host register interface of the keyboard controller.
// Assumes single-cycle host strobes. rd_data always shows the byte that a
// data read in the current cycle would return. A command write takes
// precedence over a data write in the same cycle.
module kbc_top
    import kbc_pkg::*;
#(
    parameter int         DEPTH    = 16,
    parameter logic [7:0] CFG_INIT = 8'h41
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_wr,
    input  logic       data_wr,
    input  logic       data_rd,
    input  logic [7:0] wr_data,
    output logic [7:0] status_o,
    output logic [7:0] rd_data,
    input  logic       key_valid,
    input  logic [6:0] key_code,
    input  logic       key_release,
    output logic       kbd_irq,
    output logic       sys_reset_req,
    output logic       a20_gate
);

    cmd_dec_t   dec;
    logic [7:0] resp_q, cfg_q, fifo_din, fifo_head;
    logic       resp_valid_q, waiting_q, a20_q, rst_req_q, irq_q;
    arg_kind_e  arg_q;
    logic       arg_write, host_push, fifo_push, fifo_pop;
    logic       fifo_empty, fifo_full, fifo_accept;

    kbc_cmd_decode u_dec (
        .cmd_i (wr_data),
        .dec_o (dec)
    );

    // Select the queue writer: key events win over a host-inserted byte
    always_comb begin
        arg_write = data_wr && !cmd_wr && waiting_q;
        host_push = arg_write && (arg_q == ARG_KEYBUF) && !key_valid;
        fifo_push = key_valid || host_push;
        fifo_din  = key_valid ? {key_release, key_code} : wr_data;
        fifo_pop  = data_rd && !resp_valid_q;
    end

    kbc_scan_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (fifo_push),
        .push_data_i (fifo_din),
        .pop_i       (fifo_pop),
        .head_o      (fifo_head),
        .empty_o     (fifo_empty),
        .full_o      (fifo_full),
        .accept_o    (fifo_accept)
    );

    // Execute commands and command arguments; hold controller state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q       <= 8'h00;
            resp_valid_q <= 1'b0;
            waiting_q    <= 1'b0;
            arg_q        <= ARG_CFG;
            cfg_q        <= CFG_INIT;
            a20_q        <= 1'b1;
            rst_req_q    <= 1'b0;
        end else begin
            rst_req_q <= 1'b0;
            if (data_rd && resp_valid_q) resp_valid_q <= 1'b0;
            if (cmd_wr) begin
                if (dec.gives_resp) begin
                    resp_q       <= dec.resp_from_cfg ? cfg_q : dec.resp_const;
                    resp_valid_q <= 1'b1;
                end
                if (dec.takes_arg) begin
                    waiting_q <= 1'b1;
                    arg_q     <= dec.arg_kind;
                end
                if (dec.sys_reset) rst_req_q <= 1'b1;
            end else if (arg_write) begin
                waiting_q <= 1'b0;
                case (arg_q)
                    ARG_CFG:     cfg_q <= wr_data;
                    ARG_OUTPORT: begin
                        a20_q     <= wr_data[1];
                        rst_req_q <= !wr_data[0];
                    end
                    default: ;
                endcase
            end
        end
    end

    // Pulse the interrupt for each key event the queue accepted
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= key_valid && fifo_accept;
    end

    // Build the host-visible status and read data
    always_comb begin
        status_o = {4'b0000, waiting_q, 1'b1, 1'b0, resp_valid_q || !fifo_empty};
        if (resp_valid_q)     rd_data = resp_q;
        else if (!fifo_empty) rd_data = fifo_head;
        else                  rd_data = 8'h00;
        kbd_irq       = irq_q;
        sys_reset_req = rst_req_q;
        a20_gate      = a20_q;
    end

endmodule

// File: rtl/kbc_checker.sv
// Module kbc_checker: temporal properties of kbc_top, attached with bind.
// Observes ports plus the queue-full flag of the internal queue.
module kbc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_wr,
    input logic       data_wr,
    input logic [7:0] wr_data,
    input logic [7:0] status_o,
    input logic [7:0] rd_data,
    input logic       key_valid,
    input logic       kbd_irq,
    input logic       sys_reset_req,
    input logic       a20_gate,
    input logic       q_full
);

    // R2
    self_test_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && (wr_data == 8'hAA) |=> status_o[0] && (rd_data == 8'h55));

    // R3
    arg_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && (wr_data == 8'h60) |=> status_o[3]);

    // R6
    reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && (wr_data == 8'hFE) |=> sys_reset_req);

    // R8
    irq_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kbd_irq |-> status_o[0]);

    // R9
    full_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid && q_full |=> !kbd_irq);

    // R11
    stray_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr && !cmd_wr && !status_o[3] |=> $stable(a20_gate));

endmodule

bind kbc_top kbc_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_wr        (cmd_wr),
    .data_wr       (data_wr),
    .wr_data       (wr_data),
    .status_o      (status_o),
    .rd_data       (rd_data),
    .key_valid     (key_valid),
    .kbd_irq       (kbd_irq),
    .sys_reset_req (sys_reset_req),
    .a20_gate      (a20_gate),
    .q_full        (fifo_full)
);

// File: tb/kbc_top_test.sv
// Bench kbc_top_test: directed scenarios, one task each. Inputs are driven
// and outputs sampled on the falling clock edge.
module kbc_top_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0, data_wr = 1'b0, data_rd = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] status_o, rd_data;
    logic       key_valid = 1'b0, key_release = 1'b0;
    logic [6:0] key_code = 7'h00;
    logic       kbd_irq, sys_reset_req, a20_gate;
    int         checks = 0, fails = 0;

    always #2 clk = ~clk;

    kbc_top #(.DEPTH(4), .CFG_INIT(8'h41)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .data_wr(data_wr),
        .data_rd(data_rd), .wr_data(wr_data), .status_o(status_o),
        .rd_data(rd_data), .key_valid(key_valid), .key_code(key_code),
        .key_release(key_release), .kbd_irq(kbd_irq),
        .sys_reset_req(sys_reset_req), .a20_gate(a20_gate)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr_cmd(input logic [7:0] b);
        @(negedge clk); cmd_wr = 1'b1; wr_data = b;
        @(negedge clk); cmd_wr = 1'b0;
    endtask

    task automatic wr_dat(input logic [7:0] b);
        @(negedge clk); data_wr = 1'b1; wr_data = b;
        @(negedge clk); data_wr = 1'b0;
    endtask

    // Check the byte on rd_data, then consume it
    task automatic rd_dat(input string req, input logic [7:0] exp);
        @(negedge clk); chk(req, rd_data, exp); data_rd = 1'b1;
        @(negedge clk); data_rd = 1'b0;
    endtask

    task automatic key(input logic [6:0] c, input logic rel, input logic exp_irq, input string req);
        @(negedge clk); key_valid = 1'b1; key_code = c; key_release = rel;
        @(negedge clk); key_valid = 1'b0;
        chk(req, {7'b0, kbd_irq}, {7'b0, exp_irq});
    endtask

    task automatic t_reset;
        chk("R1 reset status", status_o, 8'h04);
        chk("R7 empty read", rd_data, 8'h00);
        chk("R5 a20 reset", {7'b0, a20_gate}, 8'h01);
        chk("R6 no reset req", {7'b0, sys_reset_req}, 8'h00);
    endtask

    task automatic t_responses;
        wr_cmd(8'h20);
        chk("R1 resp status", status_o, 8'h05);
        rd_dat("R2 cfg read", 8'h41);
        chk("R7 resp cleared", status_o, 8'h04);
        wr_cmd(8'hAA);
        rd_dat("R2 self test", 8'h55);
        wr_cmd(8'hA9);
        chk("R2 aux status", status_o, 8'h05);
        rd_dat("R2 aux test", 8'h00);
    endtask

    task automatic t_config;
        wr_cmd(8'h60);
        chk("R3 waiting", status_o, 8'h0C);
        wr_dat(8'h3C);
        chk("R3 arg consumed", status_o, 8'h04);
        wr_cmd(8'h20);
        rd_dat("R4 new cfg", 8'h3C);
    endtask

    task automatic t_outport;
        wr_cmd(8'hD1);
        wr_dat(8'h01);
        chk("R5 a20 low", {7'b0, a20_gate}, 8'h00);
        chk("R5 no reset bit0=1", {7'b0, sys_reset_req}, 8'h00);
        wr_cmd(8'hD1);
        wr_dat(8'h02);
        chk("R5 a20 high", {7'b0, a20_gate}, 8'h01);
        chk("R5 reset bit0=0", {7'b0, sys_reset_req}, 8'h01);
        @(negedge clk);
        chk("R5 reset one cycle", {7'b0, sys_reset_req}, 8'h00);
    endtask

    task automatic t_reset_cmds;
        for (int c = 8'hF0; c <= 8'hFF; c++) begin
            wr_cmd(8'(c));
            chk($sformatf("R6 cmd %02h", c), {7'b0, sys_reset_req}, {7'b0, ~c[0]});
            @(negedge clk);
            chk("R6 pulse ends", {7'b0, sys_reset_req}, 8'h00);
        end
        chk("R6 status untouched", status_o, 8'h04);
    endtask

    task automatic t_keys;
        key(7'h1E, 1'b0, 1'b1, "R8 press irq");
        @(negedge clk);
        chk("R8 irq one cycle", {7'b0, kbd_irq}, 8'h00);
        key(7'h1E, 1'b1, 1'b1, "R8 release irq");
        chk("R1 queue status", status_o, 8'h05);
        rd_dat("R8 press code", 8'h1E);
        rd_dat("R8 release code", 8'h9E);
        chk("R7 drained status", status_o, 8'h04);
        rd_dat("R7 empty read zero", 8'h00);
    endtask

    task automatic t_full;
        for (int i = 1; i <= 4; i++) key(7'(i), 1'b0, 1'b1, "R9 fill");
        key(7'h05, 1'b0, 1'b0, "R9 refused no irq");
        for (int i = 1; i <= 4; i++) rd_dat("R9 order after full", 8'(i));
        rd_dat("R9 no extra", 8'h00);
        key(7'h06, 1'b0, 1'b1, "R9 wrap push");
        key(7'h07, 1'b1, 1'b1, "R9 wrap push");
        rd_dat("R9 wrap read", 8'h06);
        rd_dat("R9 wrap read", 8'h87);
    endtask

    task automatic t_d2;
        wr_cmd(8'hD2);
        @(negedge clk); data_wr = 1'b1; wr_data = 8'h5A;
        @(negedge clk); data_wr = 1'b0;
        chk("R10 no irq", {7'b0, kbd_irq}, 8'h00);
        chk("R10 status", status_o, 8'h05);
        rd_dat("R10 inserted byte", 8'h5A);
    endtask

    task automatic t_unknown;
        wr_cmd(8'h60);
        wr_cmd(8'h12);
        chk("R11 unknown keeps wait", status_o, 8'h0C);
        wr_cmd(8'hA7);
        chk("R11 unknown keeps wait", status_o, 8'h0C);
        wr_dat(8'h77);
        chk("R11 arg still taken", status_o, 8'h04);
        wr_dat(8'h99);
        chk("R11 stray data status", status_o, 8'h04);
        chk("R11 stray data a20", {7'b0, a20_gate}, 8'h01);
        wr_cmd(8'hAA);
        wr_cmd(8'h13);
        rd_dat("R11 unknown keeps resp", 8'h55);
        wr_cmd(8'h20);
        rd_dat("R11 stray data cfg", 8'h77);
    endtask

    task automatic t_priority;
        wr_cmd(8'hD2);
        @(negedge clk);
        data_wr = 1'b1; wr_data = 8'h22;
        key_valid = 1'b1; key_code = 7'h10; key_release = 1'b0;
        @(negedge clk); data_wr = 1'b0; key_valid = 1'b0;
        chk("R12 key irq", {7'b0, kbd_irq}, 8'h01);
        chk("R12 arg consumed", status_o, 8'h05);
        rd_dat("R12 key kept", 8'h10);
        rd_dat("R12 host byte dropped", 8'h00);
        wr_cmd(8'h60);
        @(negedge clk); cmd_wr = 1'b1; data_wr = 1'b1; wr_data = 8'hA9;
        @(negedge clk); cmd_wr = 1'b0; data_wr = 1'b0;
        chk("R12 cmd wins", status_o, 8'h0D);
        rd_dat("R12 cmd response", 8'h00);
        wr_dat(8'h41);
        wr_cmd(8'h20);
        rd_dat("R12 cfg from later arg", 8'h41);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_responses;
        t_config;
        t_outport;
        t_reset_cmds;
        t_keys;
        t_full;
        t_d2;
        t_unknown;
        t_priority;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule